// File: doc/BRIEF.md
# Victim filter-bit cache

This block is a small set-associative store that keeps nothing but per-word filter vectors. Each vector has one bit per 32-bit word of a 64-byte data line, 16 bits in all. A set bit means the checker has declared that word safe, so accesses to it need not be forwarded for checking. When the data cache displaces a line, the line's vector is written here. When the data cache later misses on a line, it looks the line up here. A hit restores the bits without asking the checker to regenerate them. A miss tells the requester that no bits are known, so every word must be treated as needing a check.

The checker's replies set or clear a single word's bit. A reply must also reach any vector held here, and any vector that is on its way back to the data cache, so that a "safe" bit cannot outlive the deallocation that cleared it. A lookup that hits gives its entry back to the data cache and frees the way, so a line has at most one copy across the two structures.

Within one clock edge, a lookup sees the array as it was before any insert sampled at the same edge.

Top module: `victim_fcache`

## Requirements
- R1: After reset every entry is invalid. Every lookup misses, and `lk_done` stays low until a lookup has completed.
- R2: A lookup sampled at rising edge k presents `lk_done`=1 with its `lk_hit` and `lk_vec` during the single cycle after edge k+3, so the latency is four edges. `lk_done` is low in the cycles before. While `lk_done` is low, `lk_hit` and `lk_vec` are zero.
- R3: A lookup of a resident line returns `lk_hit`=1 and the stored vector. Bit i of the vector belongs to word i of the line.
- R4: A lookup of a line that is not resident returns `lk_hit`=0 and an all-zero vector, which marks every word as needing a check.
- R5: A lookup hit invalidates the entry, so a second lookup of the same line misses.
- R6: A reply for a resident line writes `rp_set` into bit `rp_word` of that line's vector. A value of 1 sets the bit and 0 clears it. The other bits are left unchanged.
- R7: A reply for a line that is not resident is discarded and creates no entry. A later insert of that line stores exactly the inserted vector.
- R8: A reply that matches the line of a lookup hit in flight, sampled at any edge from k through k+3, is applied to the vector that the lookup returns.
- R9: Inserting a line that is already resident overwrites its vector in place and makes it the most recently inserted. Inserting a new line into a full set evicts the least recently inserted line of that set.
- R10: An insert into a set with a free way uses that way and evicts nothing.
- R11: A reply sampled at the same edge as an insert of the same line is applied to the vector being stored.
- R12: The set index is the low log2(SETS) bits of the line address. Sets are independent, and each set holds WAYS lines at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert a displaced line's vector |
| ins_line | input | LA | Line address of the insert |
| ins_vec | input | VW | Filter vector to store |
| lk_valid | input | 1 | Start a lookup |
| lk_line | input | LA | Line address to look up |
| lk_done | output | 1 | Lookup result is valid this cycle |
| lk_hit | output | 1 | Line was resident; the entry has been handed over |
| lk_vec | output | VW | Restored filter vector, zero on a miss |
| rp_valid | input | 1 | Checker reply present |
| rp_set | input | 1 | 1 sets the word's bit, 0 clears it |
| rp_line | input | LA | Line address of the reply |
| rp_word | input | $clog2(VW) | Word index within the line |

## Verification
The hardest case to reach from the ports is a reply that lands while a hit is in the lookup pipeline. By then the entry has already left the array, so only the in-flight copy can take the update. The stimulus starts one lookup and sends a different reply on each of the four edges of that lookup's latency, including the edge that samples the lookup. The expected vector is those four bit edits applied to the inserted value. Eviction order needs sets that are filled past capacity after in-place refreshes. Every set is swept in that way, and each line's presence is predicted by an arithmetic insertion-stamp model.

// File: rtl/victim_fcache.sv
module victim_fcache #(
  parameter int LA   = 26,
  parameter int SETS = 16,
  parameter int WAYS = 8,
  parameter int VW   = 16,
  parameter int LAT  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ins_valid,
  input  logic [LA-1:0]         ins_line,
  input  logic [VW-1:0]         ins_vec,
  input  logic                  lk_valid,
  input  logic [LA-1:0]         lk_line,
  output logic                  lk_done,
  output logic                  lk_hit,
  output logic [VW-1:0]         lk_vec,
  input  logic                  rp_valid,
  input  logic                  rp_set,
  input  logic [LA-1:0]         rp_line,
  input  logic [$clog2(VW)-1:0] rp_word
);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = LA - SET_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [VW-1:0]    vec_q [SETS][WAYS];
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAYS-1:0]  val_q [SETS];

  function automatic logic [VW-1:0] upd(input logic [VW-1:0] v, input logic [LA-1:0] l);
    upd = v;
    if (rp_valid && rp_line == l) upd[rp_word] = rp_set;
  endfunction

  wire [SET_W-1:0] lk_set = lk_line[SET_W-1:0];
  wire [TAG_W-1:0] lk_tag = lk_line[LA-1:SET_W];
  wire [SET_W-1:0] in_set = ins_line[SET_W-1:0];
  wire [TAG_W-1:0] in_tag = ins_line[LA-1:SET_W];
  wire [SET_W-1:0] rp_s   = rp_line[SET_W-1:0];
  wire [TAG_W-1:0] rp_tag = rp_line[LA-1:SET_W];

  logic             lk_hit_c, in_hit, free_ok, rp_hit;
  logic [WAY_W-1:0] lk_way, in_hway, free_way, lru_way, in_way, rp_way;
  logic [VW-1:0]    lk_raw;

  always_comb begin
    lk_hit_c = 1'b0; lk_way = '0; lk_raw = '0;
    in_hit = 1'b0; in_hway = '0;
    free_ok = 1'b0; free_way = '0; lru_way = '0;
    rp_hit = 1'b0; rp_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (val_q[lk_set][w] && tag_q[lk_set][w] == lk_tag) begin
        lk_hit_c = 1'b1; lk_way = WAY_W'(w); lk_raw = vec_q[lk_set][w];
      end
      if (val_q[in_set][w] && tag_q[in_set][w] == in_tag) begin
        in_hit = 1'b1; in_hway = WAY_W'(w);
      end
      if (!val_q[in_set][w]) begin
        free_ok = 1'b1; free_way = WAY_W'(w);
      end
      if (age_q[in_set][w] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
      if (val_q[rp_s][w] && tag_q[rp_s][w] == rp_tag) begin
        rp_hit = 1'b1; rp_way = WAY_W'(w);
      end
    end
  end

  assign in_way = in_hit ? in_hway : (free_ok ? free_way : lru_way);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        val_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
    end else begin
      if (lk_valid && lk_hit_c) val_q[lk_set][lk_way] <= 1'b0;
      if (ins_valid) begin
        val_q[in_set][in_way] <= 1'b1;
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == in_way)
            age_q[in_set][w] <= '0;
          else if (age_q[in_set][w] < age_q[in_set][in_way])
            age_q[in_set][w] <= age_q[in_set][w] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rp_valid && rp_hit) vec_q[rp_s][rp_way][rp_word] <= rp_set;
    if (ins_valid) begin
      vec_q[in_set][in_way] <= upd(ins_vec, ins_line);
      tag_q[in_set][in_way] <= in_tag;
    end
  end

  logic          s_v   [LAT];
  logic          s_hit [LAT];
  logic [VW-1:0] s_vec [LAT];
  logic [LA-1:0] s_line[LAT-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_v[0] <= 1'b0; s_hit[0] <= 1'b0; s_vec[0] <= '0; s_line[0] <= '0;
    end else begin
      s_v[0]    <= lk_valid;
      s_hit[0]  <= lk_valid && lk_hit_c;
      s_vec[0]  <= (lk_valid && lk_hit_c) ? upd(lk_raw, lk_line) : '0;
      s_line[0] <= lk_line;
    end
  end

  for (genvar i = 1; i < LAT; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s_v[i] <= 1'b0; s_hit[i] <= 1'b0; s_vec[i] <= '0;
      end else begin
        s_v[i]   <= s_v[i-1];
        s_hit[i] <= s_hit[i-1];
        s_vec[i] <= s_hit[i-1] ? upd(s_vec[i-1], s_line[i-1]) : '0;
      end
    end
    if (i < LAT - 1) begin : g_line
      always_ff @(posedge clk) begin
        if (!rst_n) s_line[i] <= '0;
        else        s_line[i] <= s_line[i-1];
      end
    end
  end

  assign lk_done = s_v[LAT-1];
  assign lk_hit  = s_hit[LAT-1];
  assign lk_vec  = s_vec[LAT-1];
endmodule

// File: rtl/vfc_checker.sv
module vfc_checker #(
  parameter int VW  = 16,
  parameter int LAT = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_valid,
  input logic          lk_done,
  input logic          lk_hit,
  input logic [VW-1:0] lk_vec
);
  logic [3:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst < 4'(LAT)) since_rst <= since_rst + 1'b1;
  end

  a_r1_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < 4'(LAT)) |-> !lk_done);

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 4'(LAT)) |-> (lk_done == $past(lk_valid, 4)));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_done |-> (!lk_hit && lk_vec == '0));

  a_r4_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_done && !lk_hit) |-> (lk_vec == '0));
endmodule

bind victim_fcache vfc_checker #(.VW(VW), .LAT(LAT)) u_vfc_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid),
  .lk_done(lk_done), .lk_hit(lk_hit), .lk_vec(lk_vec)
);

// File: tb/tb_victim_fcache.sv
`timescale 1ns/1ps
module tb_victim_fcache;
  localparam int LA = 8, SETS = 4, VW = 16, NL = 1 << LA, NT = NL / SETS;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ins_valid, lk_valid, rp_valid, rp_set;
  logic [LA-1:0] ins_line, lk_line, rp_line;
  logic [VW-1:0] ins_vec;
  logic [3:0] rp_word;
  logic lk_done, lk_hit;
  logic [VW-1:0] lk_vec;

  victim_fcache #(.LA(LA), .SETS(SETS)) dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_line(ins_line), .ins_vec(ins_vec),
    .lk_valid(lk_valid), .lk_line(lk_line), .lk_done(lk_done), .lk_hit(lk_hit), .lk_vec(lk_vec),
    .rp_valid(rp_valid), .rp_set(rp_set), .rp_line(rp_line), .rp_word(rp_word));

  int checks = 0, errors = 0, stamp = 0;
  bit mv [NL];
  logic [VW-1:0] mvec [NL];
  int mst [NL];

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] pat(input int l, input int salt);
    return VW'((l * 40503 + salt * 977 + 7) ^ 32'hA5C3);
  endfunction

  task automatic m_insert(input int l, input logic [VW-1:0] v);
    if (!mv[l]) begin
      int cnt = 0, old = -1;
      for (int t = 0; t < NT; t++) begin
        int ln = t * SETS + (l % SETS);
        if (mv[ln]) begin
          cnt++;
          if (old < 0 || mst[ln] < mst[old]) old = ln;
        end
      end
      if (cnt >= 8) mv[old] = 1'b0;
    end
    mv[l] = 1'b1; mvec[l] = v; stamp++; mst[l] = stamp;
  endtask

  task automatic m_reply(input bit s, input int l, input int w);
    if (mv[l]) mvec[l][w] = s;
  endtask

  task automatic ins(input int l, input logic [VW-1:0] v);
    ins_valid = 1'b1; ins_line = LA'(l); ins_vec = v;
    @(posedge clk); #1 ins_valid = 1'b0;
    m_insert(l, v);
  endtask

  task automatic reply(input bit s, input int l, input int w);
    rp_valid = 1'b1; rp_set = s; rp_line = LA'(l); rp_word = 4'(w);
    @(posedge clk); #1 rp_valid = 1'b0;
    m_reply(s, l, w);
  endtask

  task automatic lookup(input int l, input string req);
    bit eh = mv[l];
    logic [VW-1:0] ev = eh ? mvec[l] : '0;
    lk_valid = 1'b1; lk_line = LA'(l);
    @(posedge clk); #1 lk_valid = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk(!lk_done && !lk_hit, "R2", {30'd0, lk_done, lk_hit}, 32'd0);
    @(posedge clk); #1;
    chk(lk_done && lk_hit == eh && lk_vec == ev, req,
        {14'd0, lk_done, lk_hit, lk_vec}, {14'd0, 1'b1, eh, ev});
    mv[l] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog R2: actual hung expected finished");
    errors++;
    finish_up();
  end

  initial begin
    for (int l = 0; l < NL; l++) begin mv[l] = 1'b0; mvec[l] = '0; mst[l] = 0; end
    rst_n = 1'b0; ins_valid = 1'b0; lk_valid = 1'b0; rp_valid = 1'b0;
    rp_set = 1'b0; ins_line = '0; lk_line = '0; rp_line = '0; ins_vec = '0; rp_word = '0;
    repeat (3) @(posedge clk); #1 rst_n = 1'b1;
    chk(!lk_done && !lk_hit && lk_vec == '0, "R1", {14'd0, lk_done, lk_hit, lk_vec}, 32'd0);

    // R1 / R4: every line misses after reset
    for (int l = 0; l < NL; l++) lookup(l, "R1");

    // R12: fill every set to capacity
    for (int t = 0; t < 8; t++)
      for (int s = 0; s < SETS; s++) ins(t * SETS + s, pat(t * SETS + s, 0));
    // R9: refresh tag 0 in place, then overflow each set
    for (int s = 0; s < SETS; s++) ins(s, pat(s, 5));
    for (int t = 8; t < 12; t++)
      for (int s = 0; s < SETS; s++) ins(t * SETS + s, pat(t * SETS + s, 0));

    // R6: word sweep on a resident line
    for (int w = 0; w < 16; w++) reply(w % 2 == 0, 21, w);
    reply(1'b1, 22, 9);
    reply(1'b0, 22, 0);
    lookup(21, "R6");

    // R7: reply to a non-resident line is dropped
    chk(!mv[49], "R7", {31'd0, mv[49]}, 32'd0);
    reply(1'b1, 49, 3);
    ins(49, 16'h1000);
    lookup(49, "R7");

    // R3 / R9 / R12: sweep all lines against the stamp model
    for (int l = 0; l < NL; l++) lookup(l, "R3_R9_R12");
    // R5: everything handed back, all miss now
    for (int l = 0; l < NL; l++) lookup(l, "R5");

    // R10: free way is reused before any eviction
    for (int t = 0; t < 8; t++) ins(t * SETS + 2, pat(t * SETS + 2, 3));
    lookup(3 * SETS + 2, "R10");
    ins(9 * SETS + 2, pat(9 * SETS + 2, 3));
    for (int t = 0; t < 10; t++) lookup(t * SETS + 2, "R10");

    // R8: replies on every edge of an in-flight hit
    ins(8'h31, 16'h0F0F);
    lk_valid = 1'b1; lk_line = 8'h31;
    rp_valid = 1'b1; rp_set = 1'b1; rp_line = 8'h31; rp_word = 4'd4;
    @(posedge clk); #1 lk_valid = 1'b0; rp_set = 1'b0; rp_word = 4'd0;
    @(posedge clk); #1 rp_set = 1'b1; rp_word = 4'd15;
    @(posedge clk); #1 rp_set = 1'b0; rp_word = 4'd3;
    chk(!lk_done, "R2", {31'd0, lk_done}, 32'd0);
    @(posedge clk); #1 rp_valid = 1'b0;
    chk(lk_done && lk_hit && lk_vec == 16'h8F16, "R8",
        {14'd0, lk_done, lk_hit, lk_vec}, {14'd0, 2'b11, 16'h8F16});
    mv[8'h31] = 1'b0;
    lookup(8'h31, "R5");

    // R11: reply in the same cycle as the insert of that line
    ins_valid = 1'b1; ins_line = 8'h42; ins_vec = 16'h00FF;
    rp_valid = 1'b1; rp_set = 1'b0; rp_line = 8'h42; rp_word = 4'd0;
    @(posedge clk); #1 ins_valid = 1'b0; rp_valid = 1'b0;
    m_insert(8'h42, 16'h00FE);
    lookup(8'h42, "R11");

    @(posedge clk); #1;
    finish_up();
  end
endmodule